// File: doc/BRIEF.md
# Error-Accumulating Fractional Frequency Divider

This block produces a square wave at a programmable frequency from a reference clock, with no division hardware. Two integers describe the wanted output: the number of reference ticks in one second and the target frequency in hertz. Each tick, an error accumulator grows by twice the target frequency. When it reaches the tick rate, the tick rate is subtracted and the output flips in that same cycle. Each half-period is therefore either the floor or the ceiling of the ideal tick count. The leftover fraction carries into the next interval, so the mean frequency is exact and no bias builds up over time.

A new pair of values is captured on a load strobe and held in a staging register. It takes effect at the next output flip, so the half-period in progress always finishes at its old length. A target of zero, or one above half the tick rate, cannot be produced. In that case the output is held low and an error flag is raised. Reset clears the accumulator and the output and restores a default pair given by parameters.

Top module: `fracdiv_top`

## Requirements
- R1: Every half-period lasts either floor(T/(2F)) or ceil(T/(2F)) reference ticks, where T is the active tick rate and F is the active target frequency.
- R2: Starting from a clean accumulator, exactly 4F output flips occur in any 2T consecutive ticks, so the mean frequency equals F with no drift.
- R3: With the accumulator at zero at edge 0, the number of output flips after n further rising edges is exactly floor(n·2F/T). The accumulator always stays below T.
- R4: When 2F equals T, the output flips on every reference tick.
- R5: A target of F = 0 holds the output low and drives cfg_err high for as long as that setting is active.
- R6: A target with 2F > T holds the output low and drives cfg_err high.
- R7: A pair loaded while a valid setting is active takes effect on the rising edge of the next output flip. The accumulator restarts from zero on that edge. The interval that ends on that edge has the old setting's length.
- R8: A pair loaded while an invalid setting is active takes effect on the second rising edge after the strobe, with the accumulator at zero and the output starting low.
- R9: While reset is low, and right after it is released, the output is low, the accumulator is zero and the default pair is active; cfg_err shows whether the default pair is valid.
- R10: A second strobe that arrives before a staged pair is applied replaces it, so only the latest pair takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one tick per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_stb | input | 1 | One-cycle strobe that stages ld_ticks and ld_freq |
| ld_ticks | input | TW | Reference ticks per second for the staged pair |
| ld_freq | input | FW | Target output frequency in hertz for the staged pair |
| sq_out | output | 1 | Square-wave output |
| cfg_err | output | 1 | High while the active pair cannot be produced |

## Verification
The bench covers several corner cases.
- The boundary 2F = T must flip every tick. A divider with an off-by-one in its wrap comparison would stall there, or would give up one flip per period.
- Pairs whose ratio is not an integer must mix long and short half-periods and still give exactly 4F flips in 2T ticks. A design that truncated the remainder would lose flips and fail the count.
- A load in the middle of an interval must not shorten that interval. A design that applied the pair at once would end the interval early, and the measured run would fall outside the old setting's range.
- The bench also checks the zero and above-half targets, recovery from them, two strobes in a row, and a reset in mid-run. Each of these shows up as a wrong level on cfg_err or as a phase error at the output.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;

  // action applied to the output flop on a rising edge
  typedef enum logic [1:0] {
    WV_HOLD  = 2'd0,
    WV_FLIP  = 2'd1,
    WV_CLEAR = 2'd2
  } wave_op_e;

  // a pair is producible when the target is nonzero and twice it fits in the rate
  function automatic logic rate_ok(input logic [63:0] ticks, input logic [63:0] freq);
    logic [64:0] dbl;
    dbl = {freq, 1'b0};
    return (freq != 64'd0) && (dbl <= {1'b0, ticks});
  endfunction

  // width of the accumulator sum, large enough for (ticks-1) + 2*freq
  function automatic int sum_width(input int tw, input int fw);
    return ((tw > fw + 1) ? tw : fw + 1) + 1;
  endfunction

endpackage

// File: rtl/fracdiv_stage.sv
module fracdiv_stage #(
  parameter int TW = 32,
  parameter int FW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_stb,
  input  logic [TW-1:0] ld_ticks,
  input  logic [FW-1:0] ld_freq,
  input  logic          take,
  output logic          pend,
  output logic [TW-1:0] pend_ticks,
  output logic [FW-1:0] pend_freq
);

  // staging register: a newer strobe always overwrites an older staged pair
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      pend_ticks <= '0;
      pend_freq  <= '0;
    end else if (ld_stb) begin
      pend       <= 1'b1;
      pend_ticks <= ld_ticks;
      pend_freq  <= ld_freq;
    end else if (take) begin
      pend       <= 1'b0;
    end
  end

endmodule

// File: rtl/fracdiv_active.sv
module fracdiv_active #(
  parameter int          TW        = 32,
  parameter int          FW        = 24,
  parameter int unsigned DEF_TICKS = 100_000_000,
  parameter int unsigned DEF_FREQ  = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [TW-1:0] pend_ticks,
  input  logic [FW-1:0] pend_freq,
  output logic [TW-1:0] act_ticks,
  output logic [FW-1:0] act_freq,
  output logic          act_ok,
  output logic          pend_ok
);
  import fracdiv_pkg::*;

  localparam logic [TW-1:0] DT     = TW'(DEF_TICKS);
  localparam logic [FW-1:0] DF     = FW'(DEF_FREQ);
  localparam logic          DEF_OK = rate_ok(64'(DT), 64'(DF));

  assign pend_ok = rate_ok(64'(pend_ticks), 64'(pend_freq));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ticks <= DT;
      act_freq  <= DF;
      act_ok    <= DEF_OK;
    end else if (take) begin
      act_ticks <= pend_ticks;
      act_freq  <= pend_freq;
      act_ok    <= pend_ok;
    end
  end

endmodule

// File: rtl/fracdiv_accum.sv
module fracdiv_accum #(
  parameter int TW = 32,
  parameter int FW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] act_ticks,
  input  logic [FW-1:0] act_freq,
  input  logic          act_ok,
  input  logic          restart,
  output logic [TW-1:0] acc,
  output logic          wrap
);
  import fracdiv_pkg::*;

  localparam int SW = sum_width(TW, FW);

  logic [SW-1:0] step_sum;
  logic [SW-1:0] rate_w;
  logic [SW-1:0] left_w;
  logic [TW-1:0] acc_d;

  // only addition, subtraction and comparison; no division
  assign step_sum = SW'(acc) + SW'({act_freq, 1'b0});
  assign rate_w   = SW'(act_ticks);
  assign wrap     = act_ok && (step_sum >= rate_w);
  assign left_w   = step_sum - rate_w;

  always_comb begin
    if (!act_ok || restart) acc_d = '0;
    else if (wrap)          acc_d = left_w[TW-1:0];
    else                    acc_d = step_sum[TW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_d;
  end

endmodule

// File: rtl/fracdiv_wave.sv
module fracdiv_wave (
  input  logic                 clk,
  input  logic                 rst_n,
  input  fracdiv_pkg::wave_op_e op,
  output logic                 q
);
  import fracdiv_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else begin
      unique case (op)
        WV_FLIP:  q <= ~q;
        WV_CLEAR: q <= 1'b0;
        default:  q <= q;
      endcase
    end
  end

endmodule

// File: rtl/fracdiv_top.sv
module fracdiv_top #(
  parameter int          TW        = 32,
  parameter int          FW        = 24,
  parameter int unsigned DEF_TICKS = 100_000_000,
  parameter int unsigned DEF_FREQ  = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_stb,
  input  logic [TW-1:0] ld_ticks,
  input  logic [FW-1:0] ld_freq,
  output logic          sq_out,
  output logic          cfg_err
);
  import fracdiv_pkg::*;

  // named internal events, visible to the bound checker
  logic          pend;
  logic [TW-1:0] pend_ticks;
  logic [FW-1:0] pend_freq;
  logic [TW-1:0] act_ticks;
  logic [FW-1:0] act_freq;
  logic          act_ok;
  logic          pend_ok;
  logic [TW-1:0] acc_q;
  logic          wrap_evt;
  logic          cfg_take;
  wave_op_e      wv_op;

  // staged pair moves in at a flip, or at once when nothing is being produced
  assign cfg_take = pend && (wrap_evt || !act_ok);

  always_comb begin
    if (cfg_take && !pend_ok) wv_op = WV_CLEAR;
    else if (!act_ok)         wv_op = WV_CLEAR;
    else if (wrap_evt)        wv_op = WV_FLIP;
    else                      wv_op = WV_HOLD;
  end

  assign cfg_err = ~act_ok;

  fracdiv_stage #(.TW(TW), .FW(FW)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_stb     (ld_stb),
    .ld_ticks   (ld_ticks),
    .ld_freq    (ld_freq),
    .take       (cfg_take),
    .pend       (pend),
    .pend_ticks (pend_ticks),
    .pend_freq  (pend_freq)
  );

  fracdiv_active #(
    .TW(TW), .FW(FW), .DEF_TICKS(DEF_TICKS), .DEF_FREQ(DEF_FREQ)
  ) u_active (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (cfg_take),
    .pend_ticks (pend_ticks),
    .pend_freq  (pend_freq),
    .act_ticks  (act_ticks),
    .act_freq   (act_freq),
    .act_ok     (act_ok),
    .pend_ok    (pend_ok)
  );

  fracdiv_accum #(.TW(TW), .FW(FW)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_ticks (act_ticks),
    .act_freq  (act_freq),
    .act_ok    (act_ok),
    .restart   (cfg_take),
    .acc       (acc_q),
    .wrap      (wrap_evt)
  );

  fracdiv_wave u_wave (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (wv_op),
    .q     (sq_out)
  );

endmodule

// File: rtl/fracdiv_chk.sv
module fracdiv_chk #(
  parameter int TW = 32,
  parameter int FW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sq_out,
  input logic          cfg_err,
  input logic          wrap_evt,
  input logic [TW-1:0] act_ticks,
  input logic [FW-1:0] act_freq,
  input logic [TW-1:0] acc
);

  AST_ACC_BELOW_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_err |-> (acc < act_ticks)) else $error("accumulator reached rate"); // R3

  AST_STATIC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !sq_out) else $error("output active with bad pair"); // R6

  AST_ZERO_TARGET_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (act_freq == '0) |-> cfg_err) else $error("zero target not flagged"); // R5

  AST_EDGE_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sq_out) |-> $past(wrap_evt)) else $error("flip without wrap"); // R1

  AST_CFG_AT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({act_ticks, act_freq}) |-> $past(wrap_evt || cfg_err))
    else $error("pair changed mid-interval"); // R7

endmodule

bind fracdiv_top fracdiv_chk #(.TW(TW), .FW(FW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sq_out    (sq_out),
  .cfg_err   (cfg_err),
  .wrap_evt  (wrap_evt),
  .act_ticks (act_ticks),
  .act_freq  (act_freq),
  .acc       (acc_q)
);

// File: tb/tb_fracdiv_top.sv
`timescale 1ns/1ps
module tb_fracdiv_top;
  localparam int TW = 16;
  localparam int FW = 12;
  localparam int NV = 8;
  localparam int DT = 40;
  localparam int DF = 3;
  // stimulus table: tick rate and target; expectations derived per requirement
  localparam int VT [NV] = '{10, 10, 100, 37, 256, 13, 1000, 50};
  localparam int VF [NV] = '{ 2,  5,   7,  9, 100,  6,  499,  1};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          ld_stb = 1'b0;
  logic [TW-1:0] ld_ticks = '0;
  logic [FW-1:0] ld_freq = '0;
  wire           sq_out;
  wire           cfg_err;

  fracdiv_top #(.TW(TW), .FW(FW), .DEF_TICKS(DT), .DEF_FREQ(DF)) dut (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_ticks(ld_ticks),
    .ld_freq(ld_freq), .sq_out(sq_out), .cfg_err(cfg_err)
  );

  int checks = 0;
  int fails = 0;
  bit cur = 0, prv = 0;
  int run = 0, last_run = 0;
  int told, fold;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one edge; sample away from the rising edge and track interval lengths
  task automatic step();
    @(negedge clk);
    prv = cur;
    cur = sq_out;
    if (cur != prv) begin
      last_run = run + 1;
      run = 0;
    end else run++;
  endtask

  task automatic load(input int t, input int f);
    ld_ticks = TW'(t);
    ld_freq  = FW'(f);
    ld_stb   = 1'b1;
    step();
    ld_stb   = 1'b0;
  endtask

  task automatic wait_flip();
    int k = 0;
    do begin step(); k++; end while (cur == prv && k < 5000);
  endtask

  // phase check: flips after n edges from a clean start equal floor(n*2F/T)
  task automatic phase(input int t, input int f, input bit base, input int len,
                       input string req);
    int bad_n = -1;
    int bad_v = 0;
    int bad_e = 0;
    for (int n = 1; n <= len; n++) begin
      bit e;
      step();
      e = base ^ bit'(((n * 2 * f) / t) & 1);
      if (cur != e && bad_n < 0) begin bad_n = n; bad_v = cur; bad_e = e; end
    end
    chk(bad_n < 0, req, $sformatf("phase at edge %0d", bad_n), bad_v, bad_e);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step();
    step();
    chk(sq_out == 1'b0, "R9", "sq_out in reset", sq_out, 0);
    chk(cfg_err == 1'b0, "R9", "cfg_err in reset (default valid)", cfg_err, 0);
    rst_n = 1'b1;
    cur = 1'b0; prv = 1'b0; run = 0;
    told = DT; fold = DF;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    phase(DT, DF, 1'b0, 2 * DT, "R9");

    // table walk
    for (int i = 0; i < NV; i++) begin
      int t = VT[i];
      int f = VF[i];
      int lo_o, hi_o, lo, hi, flips, lastn, bad_len;
      bit base, bad;
      load(t, f);
      wait_flip();
      lo_o = told / (2 * fold);
      hi_o = (told + 2 * fold - 1) / (2 * fold);
      chk(last_run >= lo_o && last_run <= hi_o, "R7",
          $sformatf("interval ending at apply, vector %0d", i), last_run, hi_o);
      base = cur;
      lo = t / (2 * f);
      hi = (t + 2 * f - 1) / (2 * f);
      flips = 0; lastn = 0; bad = 0; bad_len = 0;
      for (int n = 1; n <= 2 * t; n++) begin
        bit e;
        step();
        e = base ^ bit'(((n * 2 * f) / t) & 1);
        if (cur != e) bad = 1;
        if (cur != prv) begin
          if ((n - lastn) < lo || (n - lastn) > hi) bad_len = n - lastn;
          flips++;
          lastn = n;
        end
      end
      chk(!bad, "R3", $sformatf("phase vector %0d", i), bad, 0);
      chk(flips == 4 * f, (2 * f == t) ? "R4" : "R2",
          $sformatf("flips in 2T, vector %0d", i), flips, 4 * f);
      chk(bad_len == 0, "R1", $sformatf("half-period length, vector %0d", i),
          bad_len, lo);
      told = t; fold = f;
    end

    // R10: two strobes back to back, the latest wins
    wait_flip();
    load(10, 2);
    load(37, 9);
    wait_flip();
    phase(37, 9, cur, 74, "R10");
    told = 37; fold = 9;

    // R5: zero target
    load(20, 0);
    begin
      int k = 0;
      while (!cfg_err && k < 5000) begin step(); k++; end
    end
    chk(cfg_err == 1'b1, "R5", "cfg_err for zero target", cfg_err, 1);
    begin
      int hi_seen = 0;
      for (int n = 0; n < 40; n++) begin
        step();
        if (sq_out || !cfg_err) hi_seen++;
      end
      chk(hi_seen == 0, "R5", "cycles not static low", hi_seen, 0);
    end

    // R8: recover from an invalid setting
    load(20, 3);
    step();
    chk(cfg_err == 1'b0, "R8", "cfg_err after recovery", cfg_err, 1'b0);
    chk(sq_out == 1'b0, "R8", "output after recovery", sq_out, 0);
    phase(20, 3, 1'b0, 40, "R8");
    told = 20; fold = 3;

    // R6: target above half the rate
    load(10, 6);
    begin
      int k = 0;
      while (!cfg_err && k < 5000) begin step(); k++; end
    end
    chk(cfg_err == 1'b1, "R6", "cfg_err for 2F>T", cfg_err, 1);
    begin
      int hi_seen = 0;
      for (int n = 0; n < 30; n++) begin
        step();
        if (sq_out || !cfg_err) hi_seen++;
      end
      chk(hi_seen == 0, "R6", "cycles not static low", hi_seen, 0);
    end

    // R9: reset from an invalid setting restores defaults
    do_reset();
    phase(DT, DF, 1'b0, 2 * DT, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule